// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Line Routing

This block gathers up to 32 interrupt sources into one normal interrupt line and one fast interrupt line for a small processor. A rising edge on a source input records the event in a raw pending register. A mask register blocks sources. A routing register can send one source to the fast line. Among the unmasked sources that are pending and not routed to the fast line, the lowest-numbered one is latched into a one-hot selected-pending register, and its index goes into an index register.

Software reaches the five registers through a single-cycle register bus. The write strobe takes effect at the next clock edge, and read data is combinational from the current state. Both pending registers are cleared by writing ones. To acknowledge a source, software first clears its raw bit and then its selected bit. When the selected bit is cleared, the next winner is loaded at that same clock edge.

Register map, with `bus_addr` values:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | raw pending | write ones to clear | one bit per source |
| 1 | mask | read/write | 1 = source blocked |
| 2 | fast routing | read/write | 1 = source goes to the fast line |
| 3 | selected pending | write ones to clear | one-hot bit of the current winner |
| 4 | index | read only | index of the current winner |

Any other address reads 0.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask register reads all ones. The raw pending, routing, selected-pending and index registers read 0. `irq_o` and `fiq_o` are low.
- R2: A 0-to-1 change of `src_i[i]`, sampled at a clock edge, sets raw pending bit i at that edge. An input held high does not set the bit again after it has been cleared.
- R3: A write to address 0 clears each raw pending bit written with 1 and leaves bits written with 0 unchanged. A rising edge in the same cycle as a clear of that bit leaves the bit set.
- R4: A source whose mask bit is 1 still records raw pending. It is never selected and never drives `fiq_o`. Clearing its mask bit lets it be selected at the clock edge after the mask write.
- R5: When the selected-pending register is empty, a clock edge loads the lowest-numbered source that is raw-pending, unmasked and not routed to the fast line. The index register (address 4) then holds that source's number. It reads 0 while nothing is selected.
- R6: The selected-pending register holds at most one bit. That bit stays set until software writes a 1 to it at address 3. The clock edge that applies this clear also loads the next eligible winner, if there is one.
- R7: `irq_o` is high exactly while the selected-pending register is non-zero.
- R8: A write to address 2 whose data has zero or one bit set replaces the routing register. A write with two or more bits set is ignored. A routed source is excluded from selection. `fiq_o` is high while any routed source is raw-pending and unmasked.
- R9: Sources 6 and 24 are reserved. They never set raw pending, are never selected, and never raise either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs; a rising edge is an event |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address (0 raw pending, 1 mask, 2 routing, 3 selected, 4 index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hardest case to reach from the ports is a source edge that lands in the same cycle as a clear write to its raw bit. The bench first leaves a masked source pending, lets its input fall, and then drives the rising edge and the clear write on the same falling clock edge, so both act at one rising edge. The handover between two simultaneous winners is also timing-sensitive. The bench raises pairs of sources together, acknowledges the lower one in the required order, and reads the index right after the selected-pending clear to confirm the higher one was loaded at that edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [2:0] {
      RA_RAWPEND = 3'd0,
      RA_MASK    = 3'd1,
      RA_ROUTE   = 3'd2,
      RA_SELPEND = 3'd3,
      RA_INDEX   = 3'd4
   } irqc_reg_e;
endpackage

// File: rtl/irqc_pend_capture.sv
module irqc_pend_capture #(
   parameter int              N_SRC    = 32,
   parameter logic [N_SRC-1:0] RSVD_MAP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);
   logic [N_SRC-1:0] src_q;
   logic [N_SRC-1:0] rise;

   assign rise = src_i & ~src_q & ~RSVD_MAP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         pend_o <= '0;
      end else begin
         src_q  <= src_i;
         // a new edge wins over a clear in the same cycle
         pend_o <= (pend_o & ~clr_i) | rise;
      end
   end

   // R2: every sampled rising edge is visible in the pending vector next cycle
   assert_edge_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

   // R3: a cleared bit without a concurrent edge reads zero afterwards
   assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~rise) != '0) |=> ((pend_o & $past(clr_i & ~rise)) == '0));

   // R9: reserved positions never pend
   assert_rsvd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o & RSVD_MAP) == '0);
endmodule

// File: rtl/irqc_lowest_pick.sv
module irqc_lowest_pick #(
   parameter int N_SRC = 32,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N_SRC-1:0] onehot_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o    = |req_i;
   assign onehot_o = any_o ? ({{(N_SRC-1){1'b0}}, 1'b1} << idx_o) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int               N_SRC    = 32,
   parameter int               DATA_W   = 32,
   parameter int               ADDR_W   = 3,
   parameter logic [N_SRC-1:0] RSVD_MAP = 32'h0100_0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   generate
      if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_nsrc
         $error("irqc_top: N_SRC must be in 2..DATA_W");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("irqc_top: ADDR_W must be at least 3");
      end
   endgenerate

   logic [N_SRC-1:0] raw_pend, mask_q, route_q, sel_q, sel_kept;
   logic [N_SRC-1:0] raw_clr, sel_clr, elig, pick_oh, wdat;
   logic [IDX_W-1:0] idx_q, pick_idx;
   logic             pick_any;
   logic             wr_raw, wr_mask, wr_route, wr_sel;

   assign wdat     = bus_wdata[N_SRC-1:0];
   assign wr_raw   = bus_wr && (bus_addr == ADDR_W'(RA_RAWPEND));
   assign wr_mask  = bus_wr && (bus_addr == ADDR_W'(RA_MASK));
   assign wr_route = bus_wr && (bus_addr == ADDR_W'(RA_ROUTE));
   assign wr_sel   = bus_wr && (bus_addr == ADDR_W'(RA_SELPEND));
   assign raw_clr  = wr_raw ? wdat : '0;
   assign sel_clr  = wr_sel ? wdat : '0;

   irqc_pend_capture #(.N_SRC(N_SRC), .RSVD_MAP(RSVD_MAP)) u_cap (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(raw_clr), .pend_o(raw_pend));

   assign elig = raw_pend & ~mask_q & ~route_q;

   irqc_lowest_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .req_i(elig), .any_o(pick_any), .idx_o(pick_idx), .onehot_o(pick_oh));

   assign sel_kept = sel_q & ~sel_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         route_q <= '0;
      end else begin
         if (wr_mask) mask_q <= wdat;
         if (wr_route && $onehot0(wdat)) route_q <= wdat & ~RSVD_MAP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         idx_q <= '0;
      end else if (sel_kept != '0) begin
         sel_q <= sel_kept;
      end else if (pick_any) begin
         sel_q <= pick_oh;
         idx_q <= pick_idx;
      end else begin
         sel_q <= '0;
         idx_q <= '0;
      end
   end

   assign irq_o = |sel_q;
   assign fiq_o = |(raw_pend & ~mask_q & route_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(RA_RAWPEND): bus_rdata[N_SRC-1:0] = raw_pend;
         ADDR_W'(RA_MASK):    bus_rdata[N_SRC-1:0] = mask_q;
         ADDR_W'(RA_ROUTE):   bus_rdata[N_SRC-1:0] = route_q;
         ADDR_W'(RA_SELPEND): bus_rdata[N_SRC-1:0] = sel_q;
         ADDR_W'(RA_INDEX):   bus_rdata[IDX_W-1:0] = idx_q;
         default:             bus_rdata = '0;
      endcase
   end

   // R6: at most one selected bit
   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q));

   // R5: index register points at the selected bit
   assert_index_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != '0) |-> sel_q[idx_q]);

   // R5: a free selection slot with an eligible source is filled next cycle
   assert_load_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_kept == '0) && (elig != '0)) |=> (sel_q != '0));

   // R8: routing register never holds more than one source
   assert_route_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_q));

   // R4: a newly loaded selection was unmasked when it was picked
   assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_kept == '0) && pick_any) |=> ((sel_q & $past(mask_q)) == '0));
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int checks = 0;
   int errors = 0;

   localparam logic [31:0] RSVD = 32'h0100_0040;

   irqc_top u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o));

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk); src_i = v;
      @(negedge clk); src_i = '0;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd1, d); check("R1 mask", d, 32'hFFFF_FFFF);
      rd(3'd0, d); check("R1 raw", d, 0);
      rd(3'd2, d); check("R1 route", d, 0);
      rd(3'd3, d); check("R1 sel", d, 0);
      rd(3'd4, d); check("R1 index", d, 0);
      check("R1 irq", {31'd0, irq_o}, 0);
      check("R1 fiq", {31'd0, fiq_o}, 0);

      // R4 masked source records but is not selected
      pulse(32'h8);
      @(negedge clk);
      rd(3'd0, d); check("R4 raw while masked", d, 32'h8);
      rd(3'd3, d); check("R4 sel while masked", d, 0);
      check("R4 irq while masked", {31'd0, irq_o}, 0);
      wr(3'd1, ~32'h8);
      @(negedge clk);
      rd(3'd3, d); check("R4 sel after unmask", d, 32'h8);
      wr(3'd0, 32'h8); wr(3'd3, 32'h8);

      // R5 R7 R9 sweep over every source, all unmasked
      wr(3'd1, 32'h0);
      for (int i = 0; i < 32; i++) begin
         logic [31:0] eb;
         eb = RSVD[i] ? 32'h0 : (32'h1 << i);
         pulse(32'h1 << i);
         @(negedge clk);
         rd(3'd0, d); check("R2 R9 raw sweep", d, eb);
         rd(3'd3, d); check("R5 R9 sel sweep", d, eb);
         rd(3'd4, d); check("R5 index sweep", d, RSVD[i] ? 0 : i);
         check("R7 irq sweep", {31'd0, irq_o}, {31'd0, !RSVD[i]});
         wr(3'd0, 32'h1 << i);
         wr(3'd3, 32'h1 << i);
         check("R7 irq after ack", {31'd0, irq_o}, 0);
      end

      // R6 priority pairs and handover at the clear edge
      for (int p = 0; p < 4; p++) begin
         int a, b;
         a = (p == 0) ? 0 : (p == 1) ? 2 : (p == 2) ? 11 : 15;
         b = (p == 0) ? 31 : (p == 1) ? 30 : (p == 2) ? 12 : 16;
         pulse((32'h1 << a) | (32'h1 << b));
         @(negedge clk);
         rd(3'd4, d); check("R5 lower wins", d, a);
         wr(3'd0, 32'h1 << a);
         rd(3'd3, d); check("R6 sel held", d, 32'h1 << a);
         wr(3'd3, 32'h1 << a);
         rd(3'd4, d); check("R6 next winner index", d, b);
         rd(3'd3, d); check("R6 next winner sel", d, 32'h1 << b);
         wr(3'd0, 32'h1 << b); wr(3'd3, 32'h1 << b);
      end

      // R3 zero bits untouched
      wr(3'd1, 32'hFFFF_FFFF);
      pulse(32'h210);
      wr(3'd0, 32'h200);
      rd(3'd0, d); check("R3 partial clear", d, 32'h10);
      wr(3'd0, 32'h10);

      // R3 edge wins over same-cycle clear
      pulse(32'h20);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h20; src_i = 32'h20;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(3'd0, d); check("R3 edge beats clear", d, 32'h20);
      // R2 held level does not re-set
      wr(3'd0, 32'h20);
      @(negedge clk);
      rd(3'd0, d); check("R2 held level", d, 0);
      src_i = '0;
      @(negedge clk);

      // R8 fast routing
      wr(3'd1, 32'h0);
      wr(3'd2, 32'h200);
      rd(3'd2, d); check("R8 route write", d, 32'h200);
      wr(3'd2, 32'h3);
      rd(3'd2, d); check("R8 multi-bit ignored", d, 32'h200);
      @(negedge clk); src_i = 32'h1200;
      @(negedge clk); src_i = '0;
      check("R8 fiq high", {31'd0, fiq_o}, 1);
      @(negedge clk);
      rd(3'd4, d); check("R8 routed excluded", d, 12);
      rd(3'd3, d); check("R8 sel normal only", d, 32'h1000);
      wr(3'd1, 32'h200);
      check("R4 fiq masked", {31'd0, fiq_o}, 0);
      wr(3'd0, 32'h1200); wr(3'd3, 32'h1000);
      wr(3'd2, 32'h0);
      rd(3'd2, d); check("R8 route cleared", d, 0);
      check("R7 idle irq", {31'd0, irq_o}, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule